// File: doc/BRIEF.md
# Converter Start Sequencer with Recovery Counter

This block sits between a system that asks for analog-to-digital conversions and a converter that flags "busy" by pulling its end-of-conversion line low and then needs a few clock periods of quiet after that line returns high before it can take another start. A request line, which may change at any time relative to the clock, is brought into the clock domain and held in a pending latch. The sequencer turns the pending request into a start pulse one clock wide. At the same moment it preloads a small binary counter. The counter does not move while end-of-conversion is low. Once that line is high it counts up to its terminal value, and the carry marks the end of the recovery interval.

The carry appears on the `ready` output as a one-clock strobe. The strobe means the converter's result has settled on its outputs and a new conversion may be asked for. The same carry clears the pending latch. If the request line is still high when the carry occurs, the next start pulse follows on the very next clock. Holding the request high therefore gives conversions back to back.

The sequencer has four named states:
- IDLE waits for a pending request.
- FIRE drives the start pulse and loads the counter.
- ARM waits for the converter to drop end-of-conversion.
- COUNT runs the recovery counter.

Its transitions are:
- IDLE to FIRE on a pending request.
- FIRE to ARM unconditionally.
- ARM to COUNT when end-of-conversion is low.
- COUNT to FIRE on carry with the request still high.
- COUNT to IDLE on carry with the request low.

Top module: `conv_start_seq`

## Requirements
- R1: After reset both outputs are low, the pending latch is clear, and no start pulse is issued until a new request arrives. This holds even if a request was pending when reset was applied.
- R2: Each start pulse on `conv_start` is exactly one clock period wide.
- R3: With the sequencer idle, a request raised just before a clock edge produces a start pulse that is high during the clock period following the fourth rising edge (two synchronizer stages, latch, state register). A request that lasts three clocks yields exactly one conversion.
- R4: The counter is loaded with 11 when the start pulse is issued. `ready` is high during the clock period following the fourth rising edge at which `eoc` is sampled high. This holds whatever the length of the conversion.
- R5: While the counter is running, any clock edge at which `eoc` is sampled low does not advance it. Each such edge delays `ready` by one clock.
- R6: `ready` is one clock wide. After its carry the counter holds its terminal value (15), and no further `ready` appears until a new start pulse.
- R7: If the synchronized request is still high at the edge where `ready` ends, `conv_start` is high in the very next clock period.
- R8: The carry clears the pending latch. A request pulse that arrives and ends during a conversion, and is low again by the carry, causes no additional conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the converter |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_async | input | 1 | Conversion request; may be asynchronous; held high for continuous conversion |
| eoc | input | 1 | End-of-conversion from the converter; low while busy |
| conv_start | output | 1 | One-clock start pulse to the converter |
| ready | output | 1 | One-clock carry strobe: result valid, ready for a new cycle |

## Verification
Each kind of internal fault shows up at the ports within a few clocks:
- A wrong counter preload or a count that keeps running while `eoc` is low moves the `ready` strobe away from its expected clock. The scoreboard catches this on the first conversion after the fault.
- A carry that fails to clear the pending latch appears as an extra start pulse within about two clocks of `ready`.
- A counter that wraps past its terminal value gives a repeated `ready`.
- A state register stuck in FIRE gives a start pulse two clocks wide.

A missing hand-off from COUNT to FIRE under a held request is visible one clock after `ready`, as a missing start.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRE  = 2'd1,
        ST_ARM   = 2'd2,
        ST_COUNT = 2'd3
    } seq_state_t;

endpackage

// File: rtl/req_sync.sv
module req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/recov_counter.sv
module recov_counter #(
    parameter int                 WIDTH    = 4,
    parameter logic [WIDTH-1:0]   LOAD_VAL = 4'd11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             en,
    output logic [WIDTH-1:0] cnt,
    output logic             carry
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt_q;

    assign carry = (cnt_q == TOP);
    assign cnt   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= TOP;
        else if (load)           cnt_q <= LOAD_VAL;
        else if (en && !carry)   cnt_q <= cnt_q + 1'b1;
    end

    // R6: once at the terminal value the counter stays there until reloaded
    assert_hold_at_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !load) |=> (cnt == TOP));

    // R5: no advance without enable
    assert_no_step_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(cnt));
endmodule

// File: rtl/conv_start_seq.sv
module conv_start_seq
    import conv_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4,
    parameter int RECOVER_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    input  logic eoc,
    output logic conv_start,
    output logic ready
);
    localparam int               LOAD_INT = (1 << CNT_W) - 1 - RECOVER_CYC;
    localparam logic [CNT_W-1:0] LOAD_V   = LOAD_INT[CNT_W-1:0];

    seq_state_t       state_q, state_d;
    logic             req_s;
    logic             pend_q;
    logic [CNT_W-1:0] cnt;
    logic             carry;
    logic             cnt_load, cnt_en;

    req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_async),
        .q     (req_s)
    );

    recov_counter #(.WIDTH(CNT_W), .LOAD_VAL(LOAD_V)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .en    (cnt_en),
        .cnt   (cnt),
        .carry (carry)
    );

    // pending-request latch: set by the synchronized request, cleared by carry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (ready) pend_q <= 1'b0;
        else if (req_s) pend_q <= 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pend_q) state_d = ST_FIRE;
            ST_FIRE:  state_d = ST_ARM;
            ST_ARM:   if (!eoc)  state_d = ST_COUNT;
            ST_COUNT: if (carry) state_d = req_s ? ST_FIRE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and counter controls
    always_comb begin
        conv_start = (state_q == ST_FIRE);
        ready      = (state_q == ST_COUNT) && carry;
        cnt_load   = (state_q == ST_FIRE);
        cnt_en     = (state_q == ST_COUNT) && eoc;
    end

    // R2: start pulse is one clock wide
    assert_start_one_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R4: start pulse loads the preload value
    assert_preload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> (cnt == LOAD_V));

    // R5: recovery count freezes while the converter reports busy
    assert_freeze_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !eoc) |=> $stable(cnt));

    // R6: ready strobe is one clock wide
    assert_ready_one_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R7: held request restarts on the next clock
    assert_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_s) |=> conv_start);

    // R8: carry clears the pending latch
    assert_latch_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !req_s) |=> !pend_q);

    // R1: nothing is started without a pending request from idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !pend_q) |=> !conv_start);
endmodule

// File: tb/tb_conv_start_seq.sv
module tb_conv_start_seq;

    typedef struct {
        int    lat;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic eoc = 1'b1;
    logic conv_start, ready;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t exp_q[$];
    int   start_cnt = 0;
    int   rise_cyc = 0;
    int   conv_len = 5;
    bit   dip_en = 1'b0;
    int   low_left = 0;
    int   dip_st = 0;
    bit   prev_start = 1'b0;
    bit   prev_done = 1'b0;
    bit   finished = 1'b0;

    conv_start_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_async  (req),
        .eoc        (eoc),
        .conv_start (conv_start),
        .ready      (ready)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_exp(input int lat, input string tag);
        exp_t e;
        e.lat = lat;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // converter model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            eoc = 1'b1;
            low_left = 0;
            dip_st = 0;
            prev_start = 1'b0;
            prev_done = 1'b0;
        end else begin
            if (prev_start) chk(!conv_start, "R2 start pulse width", int'(conv_start), 0);
            if (prev_done)  chk(!ready, "R6 ready width", int'(ready), 0);
            if (conv_start) start_cnt++;
            if (ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected ready", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk((cyc - rise_cyc) == e.lat, e.tag, cyc - rise_cyc, e.lat);
                end
            end
            if (conv_start) begin
                eoc = 1'b0;
                low_left = conv_len;
                dip_st = 0;
            end else if (low_left > 0) begin
                low_left--;
                if (low_left == 0) begin
                    eoc = 1'b1;
                    rise_cyc = cyc;
                    dip_st = dip_en ? 1 : 0;
                end
            end else if (dip_st == 1) begin
                eoc = 1'b0;
                dip_st = 2;
            end else if (dip_st == 2) begin
                dip_st = 3;
            end else if (dip_st == 3) begin
                eoc = 1'b1;
                dip_st = 0;
            end
            prev_start = conv_start;
            prev_done = ready;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // raise the request for 'hold' clocks and check the start latency (R3)
    task automatic request(input int hold);
        int c0;
        @(negedge clk);
        req = 1'b1;
        c0 = cyc;
        tick(hold);
        req = 1'b0;
        while (!conv_start && (cyc - c0) < 20) @(negedge clk);
        chk((cyc - c0) == 4, "R3 start latency", cyc - c0, 4);
    endtask

    task automatic wait_ready();
        int w;
        w = 0;
        @(negedge clk);
        while (!ready && w < 200) begin
            @(negedge clk);
            w++;
        end
    endtask

    initial begin
        int base;
        // R1: reset state
        tick(2);
        chk(!conv_start, "R1 start low in reset", int'(conv_start), 0);
        chk(!ready, "R1 ready low in reset", int'(ready), 0);
        rst_n = 1'b1;
        tick(10);
        chk(start_cnt == 0, "R1 no start after reset", start_cnt, 0);
        chk(!ready, "R1 ready low after reset", int'(ready), 0);

        // R3/R4: single short request, short conversion
        conv_len = 5;
        push_exp(4, "R4 ready latency short conv");
        request(3);
        wait_ready();
        tick(20);
        chk(start_cnt == 1, "R3 one conversion per request", start_cnt, 1);

        // R4: long conversion, same recovery
        conv_len = 40;
        push_exp(4, "R4 ready latency long conv");
        request(2);
        wait_ready();
        tick(10);

        // R5: eoc dips low during recovery, two frozen edges
        conv_len = 6;
        dip_en = 1'b1;
        push_exp(6, "R5 ready latency with eoc dip");
        request(3);
        wait_ready();
        dip_en = 1'b0;
        tick(10);

        // R8: pulse during conversion is absorbed by the carry
        conv_len = 12;
        base = start_cnt;
        push_exp(4, "R8 ready latency");
        request(3);
        tick(2);
        req = 1'b1;
        tick(3);
        req = 1'b0;
        wait_ready();
        tick(25);
        chk(start_cnt == base + 1, "R8 no extra conversion", start_cnt - base, 1);

        // R7: held request, back-to-back conversions
        conv_len = 5;
        base = start_cnt;
        for (int k = 0; k < 4; k++) push_exp(4, "R7 ready latency held");
        @(negedge clk);
        req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            wait_ready();
            @(negedge clk);
            chk(conv_start == 1'b1, "R7 start right after ready", int'(conv_start), 1);
        end
        req = 1'b0;
        wait_ready();
        tick(20);
        chk(start_cnt == base + 4, "R7 held-request conversion count", start_cnt - base, 4);
        chk(exp_q.size() == 0, "R6 all expected ready seen", exp_q.size(), 0);

        // R1: reset clears a pending request
        base = start_cnt;
        @(negedge clk);
        req = 1'b1;
        tick(3);
        rst_n = 1'b0;
        req = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(20);
        chk(start_cnt == base, "R1 reset clears pending request", start_cnt - base, 0);
        chk(!ready, "R1 ready low after second reset", int'(ready), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule